// File: doc/BRIEF.md
# Per-Opcode Taint Shortcut Filter

This block sits in front of a slower taint propagation path (a result cache backed by a software handler). Each retiring instruction presents its opcode and up to three input taint states: two source registers and, for instructions that touch memory, the memory word's state. A per-opcode policy table holds a 2-bit mode for each of the 256 opcodes. The mode says which shortcuts are safe for that opcode. In the same cycle, the filter either produces the output taint state itself or raises a request for the slow lookup.

Two shortcuts exist. The zero rule maps all-clean inputs to a clean output. The unary rule passes the state of the single non-zero input through unchanged. The table is loaded and read back one byte at a time, so that its 512 bits can be saved and restored as 64 bytes on a context switch.

Top module: `tpf_filter`

## Requirements
- R1: Writing `cfg_wdata` to byte `cfg_addr` = k sets the mode of opcode 4k+j to bits [2j+1:2j] of that byte, for j = 0..3. The new modes take effect from the next clock edge.
- R2: After reset, every one of the 256 modes is 00, so all 64 bytes read back as 0.
- R3: `cfg_rdata` shows the stored byte selected by `cfg_addr` combinationally, in the same cycle. In a cycle that also writes that byte, it still shows the old contents.
- R4: Mode 01 (zero only): if every counted input is zero, the request resolves with state 0. Any non-zero counted input raises need-lookup.
- R5: Mode 10 (zero and unary): all-zero counted inputs resolve to 0. Exactly one non-zero counted input resolves to that input's state. Two or more non-zero counted inputs raise need-lookup.
- R6: Mode 00 (no shortcut) and mode 11 (reserved, treated as 00) raise need-lookup for every valid request.
- R7: The memory state is counted only when `req_mem_used` is 1. Otherwise its value has no effect on the outputs.
- R8: For each valid request, exactly one of `res_resolved` and `res_lookup` is 1. With `req_valid` low, both are 0. `res_state` is 0 whenever the request is not resolved.
- R9: The decision is combinational and uses the mode stored before the current clock edge. A write to the opcode's byte in the same cycle affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Write one table byte |
| cfg_addr | input | 6 | Byte index for write and read-back |
| cfg_wdata | input | 8 | Byte holding four opcode modes |
| cfg_rdata | output | 8 | Stored byte at `cfg_addr` |
| req_valid | input | 1 | Request present |
| req_opcode | input | 8 | Instruction opcode |
| req_src1 | input | ST_W | First source register state |
| req_src2 | input | ST_W | Second source register state |
| req_mem | input | ST_W | Memory word state |
| req_mem_used | input | 1 | Instruction accesses memory |
| res_resolved | output | 1 | Output produced by a shortcut |
| res_state | output | ST_W | Output taint state when resolved |
| res_lookup | output | 1 | Slow lookup needed |

## Verification
The assertions assume the request inputs are settled and free of X whenever `req_valid` is high. They also assume that a byte written with `cfg_we` is read back only when `cfg_addr` is held across the edge. The bench meets both conditions by driving all inputs once per cycle on the falling edge from a fixed-seed `$urandom` stream. It biases the states toward zero so that the zero, single-non-zero and multi-non-zero cases all occur often. Directed cases cover reset contents, every mode, an ignored memory state, and a write in the same cycle as a request.

// File: rtl/tpf_pkg.sv
package tpf_pkg;
    localparam int MODE_W = 2;
    localparam int N_SRC  = 3;

    typedef enum logic [MODE_W-1:0] {
        MODE_OFF   = 2'b00,
        MODE_ZERO  = 2'b01,
        MODE_UNARY = 2'b10,
        MODE_RSVD  = 2'b11
    } tpf_mode_e;
endpackage

// File: rtl/tpf_table.sv
module tpf_table
    import tpf_pkg::*;
#(
    parameter int OPC_W  = 8,
    parameter int BYTE_W = 8,
    localparam int N_OPC  = 1 << OPC_W,
    localparam int LANES  = BYTE_W / MODE_W,
    localparam int LBITS  = $clog2(LANES),
    localparam int ADDR_W = OPC_W - LBITS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    input  logic [OPC_W-1:0]  opc,
    output logic [MODE_W-1:0] opc_mode
);
    logic [MODE_W-1:0] ent_q [N_OPC];

    // one register per opcode; lane g%LANES of byte g/LANES
    for (genvar g = 0; g < N_OPC; g++) begin : g_ent
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q[g] <= MODE_OFF;
            end else if (wr_en && wr_addr == ADDR_W'(g / LANES)) begin
                ent_q[g] <= wr_data[MODE_W*(g % LANES) +: MODE_W];
            end
        end
    end

    for (genvar l = 0; l < LANES; l++) begin : g_rd
        assign rd_data[MODE_W*l +: MODE_W] = ent_q[{rd_addr, LBITS'(l)}];
    end

    assign opc_mode = ent_q[opc];
endmodule

// File: rtl/tpf_decide.sv
module tpf_decide
    import tpf_pkg::*;
#(
    parameter int ST_W = 2
) (
    input  logic              valid,
    input  logic [MODE_W-1:0] mode,
    input  logic [ST_W-1:0]   src1,
    input  logic [ST_W-1:0]   src2,
    input  logic [ST_W-1:0]   mem,
    input  logic              mem_used,
    output logic              resolved,
    output logic              lookup,
    output logic [ST_W-1:0]   state
);
    logic [ST_W-1:0] ins [N_SRC];
    logic [N_SRC-1:0] nz;
    logic [ST_W-1:0] merged;
    tpf_mode_e       md;

    assign ins[0] = src1;
    assign ins[1] = src2;
    assign ins[2] = mem_used ? mem : '0;

    for (genvar k = 0; k < N_SRC; k++) begin : g_nz
        assign nz[k] = |ins[k];
    end

    // with a single non-zero input, the OR of all inputs equals it
    always_comb begin
        merged = '0;
        for (int k = 0; k < N_SRC; k++) merged = merged | ins[k];
    end

    assign md = tpf_mode_e'(mode);

    always_comb begin
        resolved = 1'b0;
        lookup   = 1'b0;
        state    = '0;
        if (valid) begin
            unique case (md)
                MODE_ZERO: begin
                    if (nz == '0) resolved = 1'b1;
                    else          lookup   = 1'b1;
                end
                MODE_UNARY: begin
                    if ($countones(nz) <= 1) begin
                        resolved = 1'b1;
                        state    = merged;
                    end else begin
                        lookup = 1'b1;
                    end
                end
                MODE_OFF, MODE_RSVD: lookup = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/tpf_filter.sv
module tpf_filter
    import tpf_pkg::*;
#(
    parameter int ST_W   = 2,
    parameter int OPC_W  = 8,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = OPC_W - $clog2(BYTE_W / MODE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [BYTE_W-1:0] cfg_wdata,
    output logic [BYTE_W-1:0] cfg_rdata,
    input  logic              req_valid,
    input  logic [OPC_W-1:0]  req_opcode,
    input  logic [ST_W-1:0]   req_src1,
    input  logic [ST_W-1:0]   req_src2,
    input  logic [ST_W-1:0]   req_mem,
    input  logic              req_mem_used,
    output logic              res_resolved,
    output logic [ST_W-1:0]   res_state,
    output logic              res_lookup
);
    logic [MODE_W-1:0] cur_mode;

    tpf_table #(.OPC_W(OPC_W), .BYTE_W(BYTE_W)) i_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_addr  (cfg_addr),
        .wr_data  (cfg_wdata),
        .rd_addr  (cfg_addr),
        .rd_data  (cfg_rdata),
        .opc      (req_opcode),
        .opc_mode (cur_mode)
    );

    tpf_decide #(.ST_W(ST_W)) i_decide (
        .valid    (req_valid),
        .mode     (cur_mode),
        .src1     (req_src1),
        .src2     (req_src2),
        .mem      (req_mem),
        .mem_used (req_mem_used),
        .resolved (res_resolved),
        .lookup   (res_lookup),
        .state    (res_state)
    );
endmodule

// File: rtl/tpf_filter_chk.sv
module tpf_filter_chk #(
    parameter int ST_W   = 2,
    parameter int ADDR_W = 6,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_we,
    input logic [ADDR_W-1:0] cfg_addr,
    input logic [BYTE_W-1:0] cfg_wdata,
    input logic [BYTE_W-1:0] cfg_rdata,
    input logic              req_valid,
    input logic [ST_W-1:0]   req_src1,
    input logic [ST_W-1:0]   req_src2,
    input logic [ST_W-1:0]   req_mem,
    input logic              req_mem_used,
    input logic              res_resolved,
    input logic [ST_W-1:0]   res_state,
    input logic              res_lookup,
    input logic [1:0]        cur_mode
);
    a_r8_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $countones({res_resolved, res_lookup}) == 1);

    a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !res_resolved && !res_lookup && res_state == '0);

    a_r1_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_addr != $past(cfg_addr) || cfg_rdata == $past(cfg_wdata)));

    a_r6_no_shortcut: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && (cur_mode == 2'b00 || cur_mode == 2'b11) |-> res_lookup);

    a_r4_zero_out: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && cur_mode == 2'b01 && res_resolved |-> res_state == '0);

    a_r5_pass_source: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && res_resolved |-> res_state == '0 || res_state == req_src1 ||
            res_state == req_src2 || (req_mem_used && res_state == req_mem));

    a_r7_mem_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_mem_used && req_src1 == '0 && req_src2 == '0 &&
            (cur_mode == 2'b01 || cur_mode == 2'b10) |-> res_resolved && res_state == '0);
endmodule

bind tpf_filter tpf_filter_chk #(.ST_W(ST_W), .ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_addr     (cfg_addr),
    .cfg_wdata    (cfg_wdata),
    .cfg_rdata    (cfg_rdata),
    .req_valid    (req_valid),
    .req_src1     (req_src1),
    .req_src2     (req_src2),
    .req_mem      (req_mem),
    .req_mem_used (req_mem_used),
    .res_resolved (res_resolved),
    .res_state    (res_state),
    .res_lookup   (res_lookup),
    .cur_mode     (cur_mode)
);

// File: tb/test_tpf_filter.sv
module test_tpf_filter;
    localparam int ST_W = 2;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            cfg_we;
    logic [5:0]      cfg_addr;
    logic [7:0]      cfg_wdata;
    logic [7:0]      cfg_rdata;
    logic            req_valid;
    logic [7:0]      req_opcode;
    logic [ST_W-1:0] req_src1, req_src2, req_mem;
    logic            req_mem_used;
    logic            res_resolved, res_lookup;
    logic [ST_W-1:0] res_state;

    logic [1:0] model [256];
    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    tpf_filter #(.ST_W(ST_W)) i_tpf_filter (.*);

    task automatic chk(string rq, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", rq, got, exp);
        end
    endtask

    function automatic logic [7:0] model_byte(logic [5:0] a);
        logic [7:0] b;
        for (int j = 0; j < 4; j++) b[2*j +: 2] = model[{a, 2'(j)}];
        return b;
    endfunction

    // returns {resolved, lookup, state}
    function automatic logic [ST_W+1:0] expect_dec(logic v, logic [1:0] md,
            logic [ST_W-1:0] s1, logic [ST_W-1:0] s2, logic [ST_W-1:0] m, logic mu);
        logic [ST_W-1:0] mm;
        int n;
        logic [ST_W-1:0] one;
        mm = mu ? m : '0;
        n = (s1 != 0) + (s2 != 0) + (mm != 0);
        one = (s1 != 0) ? s1 : (s2 != 0) ? s2 : mm;
        if (!v) return '0;
        if (md == 2'b01) return (n == 0) ? {2'b10, {ST_W{1'b0}}} : {2'b01, {ST_W{1'b0}}};
        if (md == 2'b10) begin
            if (n == 0) return {2'b10, {ST_W{1'b0}}};
            if (n == 1) return {2'b10, one};
            return {2'b01, {ST_W{1'b0}}};
        end
        return {2'b01, {ST_W{1'b0}}};
    endfunction

    task automatic cycle(string tag, logic we, logic [5:0] a, logic [7:0] wd,
            logic v, logic [7:0] opc, logic [ST_W-1:0] s1, logic [ST_W-1:0] s2,
            logic [ST_W-1:0] m, logic mu);
        string rq;
        @(negedge clk);
        cfg_we = we; cfg_addr = a; cfg_wdata = wd;
        req_valid = v; req_opcode = opc; req_src1 = s1; req_src2 = s2;
        req_mem = m; req_mem_used = mu;
        #1;
        chk("R3 readback", 32'(cfg_rdata), 32'(model_byte(a)));
        if (tag != "") rq = tag;
        else if (!v) rq = "R8 idle";
        else if (model[opc] == 2'b01) rq = "R4 zero mode";
        else if (model[opc] == 2'b10) rq = "R5 unary mode";
        else rq = "R6 no shortcut";
        chk(rq, 32'({res_resolved, res_lookup, res_state}),
            32'(expect_dec(v, model[opc], s1, s2, m, mu)));
        if (we) for (int j = 0; j < 4; j++) model[{a, 2'(j)}] = wd[2*j +: 2];
    endtask

    function automatic logic [ST_W-1:0] rnd_state();
        return ($urandom % 3 == 0) ? ST_W'($urandom) : '0;
    endfunction

    initial begin
        #(8 * 200000);
        checks++;
        errors++;
        $display("FAIL watchdog actual hung expected finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'h5EED_0042);
        for (int i = 0; i < 256; i++) model[i] = 2'b00;
        rst_n = 1'b0; cfg_we = 0; cfg_addr = 0; cfg_wdata = 0;
        req_valid = 0; req_opcode = 0; req_src1 = 0; req_src2 = 0;
        req_mem = 0; req_mem_used = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R2: all bytes clear after reset
        for (int a = 0; a < 64; a++) begin
            cfg_addr = 6'(a);
            #1;
            chk("R2 reset byte", 32'(cfg_rdata), 32'h0);
        end
        cycle("R6 after reset", 0, 0, 0, 1, 8'd77, 2'd1, 2'd0, 2'd0, 0);

        // R1: byte 0 -> opc0=00, opc1=01, opc2=10, opc3=11
        cycle("", 1, 6'd0, 8'b11_10_01_00, 0, 0, 0, 0, 0, 0);
        cycle("R1 lane map", 0, 6'd0, 0, 1, 8'd1, 0, 0, 0, 0);
        cycle("R1 lane map", 0, 6'd0, 0, 1, 8'd2, 2'd3, 0, 0, 0);
        cycle("R4 nonzero", 0, 6'd0, 0, 1, 8'd1, 0, 2'd2, 0, 0);
        cycle("R5 mem single", 0, 6'd0, 0, 1, 8'd2, 0, 0, 2'd2, 1);
        cycle("R5 two nonzero", 0, 6'd0, 0, 1, 8'd2, 2'd1, 2'd2, 0, 0);
        cycle("R6 reserved", 0, 6'd0, 0, 1, 8'd3, 0, 0, 0, 0);
        cycle("R6 off", 0, 6'd0, 0, 1, 8'd0, 0, 0, 0, 1);
        // R7: memory state ignored when not used
        cycle("R7 zero mode", 0, 6'd0, 0, 1, 8'd1, 0, 0, 2'd3, 0);
        cycle("R7 unary", 0, 6'd0, 0, 1, 8'd2, 2'd1, 0, 2'd3, 0);
        // R9: same-cycle write uses old mode, next cycle the new one
        cycle("R9 old mode", 1, 6'd0, 8'h00, 1, 8'd2, 0, 2'd1, 0, 0);
        cycle("R9 new mode", 0, 6'd0, 0, 1, 8'd2, 0, 2'd1, 0, 0);
        // R1: last byte, top lane
        cycle("", 1, 6'd63, 8'b10_00_00_01, 0, 0, 0, 0, 0, 0);
        cycle("R1 top lane", 0, 6'd63, 0, 1, 8'd255, 0, 0, 2'd3, 1);
        cycle("R8 idle", 0, 6'd63, 0, 0, 8'd255, 2'd1, 0, 0, 0);

        for (int i = 0; i < 3000; i++) begin
            cycle("", ($urandom % 4) == 0, 6'($urandom), 8'($urandom),
                  ($urandom % 8) != 0, 8'($urandom % 32), rnd_state(),
                  rnd_state(), rnd_state(), 1'($urandom));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule